// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block applies one scalar operation, unchanged, to a run of consecutive register-file entries. A start pulse captures a length, an optional predicate mask, an element-width code, an operation code and three base register indices. The block then walks an element counter that is kept apart from any program counter. It visits one element per clock and writes a result for each element whose predicate allows it.

The register file is outside the block. The sequencer drives two read addresses and expects the read data back in the same cycle. It drives one write port. The element width only changes how many low bits of the 64-bit result are kept; the operation and its operands stay the same for every element. A one-cycle completion pulse tells the surrounding pipeline that it may move its program counter on.

Top module: `vec_elem_seq`

## Requirements
- R1: A start pulse seen while idle with an effective length n > 0 sets `busy` from the next cycle for exactly n cycles. During those cycles `elem_idx` counts 0, 1, ..., n-1. `done` is high for the single cycle after the last element cycle, and in that cycle `busy` is low.
- R2: A start pulse seen while idle with length 0 raises `done` in the next cycle. No write is made and `busy` stays low.
- R3: With `pred_en`=1, element i writes (`wr_en` high in its cycle) only when bit i of `pred_mask` is 1. A masked element still uses one cycle, and its destination keeps its old value.
- R4: With `pred_en`=0, every element from 0 to n-1 writes.
- R5: Element i reads registers `base_a`+i and `base_b`+i and writes register `base_d`+i, all modulo 128.
- R6: `op_sel` encodes 0=add, 1=subtract (a-b), 2=AND, 3=OR, 4=XOR. Codes 5 to 7 write zero.
- R7: `ew_code` encodes 00=64, 01=32, 10=16 and 11=8 bits. The result is cut to that width and zero-extended into the 64-bit slot, so no carry or borrow reaches the upper bits.
- R8: A start pulse seen while `busy` is ignored. Length, mask, width, operation and bases are held from the accepted start, so changing them mid-loop has no effect.
- R9: A length above 64 is treated as 64.
- R10: During and right after reset, `busy`, `done` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a loop (taken only when idle) |
| vl | input | 7 | Number of elements, 0 to 64 (higher values are clamped) |
| pred_en | input | 1 | Enable predicate gating |
| pred_mask | input | 64 | Per-element enable bits |
| ew_code | input | 2 | Element width code |
| op_sel | input | 3 | Operation code |
| base_d | input | 7 | Destination base register |
| base_a | input | 7 | First source base register |
| base_b | input | 7 | Second source base register |
| rd_addr_a | output | 7 | First source read address |
| rd_addr_b | output | 7 | Second source read address |
| rd_data_a | input | 64 | First source read data (same cycle) |
| rd_data_b | input | 64 | Second source read data (same cycle) |
| busy | output | 1 | Loop in progress |
| elem_idx | output | 6 | Element under examination |
| wr_en | output | 1 | Element issue / register write strobe |
| wr_addr | output | 7 | Write address |
| wr_data | output | 64 | Write data |
| done | output | 1 | One-cycle loop completion pulse |

## Verification
The properties assume `start` is a clean synchronous level and that the read data comes back combinationally from whatever the read addresses select. The bench meets both. It drives every input on the falling edge and serves the reads from a model register file, so the values the checker compares are stable at the rising edge. The completion-pulse property allows a zero-length start in the completion cycle, because the block legally restarts there. The stimulus never leaves `vl` or the other inputs undefined while `start` is high.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int XLEN = 64;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    EW_64 = 2'b00,
    EW_32 = 2'b01,
    EW_16 = 2'b10,
    EW_8  = 2'b11
  } ew_e;

  function automatic logic [XLEN-1:0] width_keep(input logic [1:0] ew);
    case (ew_e'(ew))
      EW_32:   width_keep = {{32{1'b0}}, {32{1'b1}}};
      EW_16:   width_keep = {{48{1'b0}}, {16{1'b1}}};
      EW_8:    width_keep = {{56{1'b0}}, {8{1'b1}}};
      default: width_keep = {XLEN{1'b1}};
    endcase
  endfunction

  function automatic logic [XLEN-1:0] scalar_op(input logic [XLEN-1:0] a,
                                                input logic [XLEN-1:0] b,
                                                input logic [2:0]      op);
    case (op)
      OP_ADD:  scalar_op = a + b;
      OP_SUB:  scalar_op = a - b;
      OP_AND:  scalar_op = a & b;
      OP_OR:   scalar_op = a | b;
      OP_XOR:  scalar_op = a ^ b;
      default: scalar_op = '0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] elem_op(input logic [XLEN-1:0] a,
                                              input logic [XLEN-1:0] b,
                                              input logic [2:0]      op,
                                              input logic [1:0]      ew);
    elem_op = scalar_op(a, b, op) & width_keep(ew);
  endfunction
endpackage

// File: rtl/vseq_subctr.sv
module vseq_subctr #(
  parameter int VL_MAX = 64,
  localparam int IDXW = $clog2(VL_MAX),
  localparam int VLW  = $clog2(VL_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VLW-1:0]  vl,
  output logic            accept,
  output logic            busy,
  output logic [IDXW-1:0] idx,
  output logic            last,
  output logic            done
);
  logic [VLW-1:0] vl_eff;
  logic [VLW-1:0] vl_q;

  assign vl_eff = (vl > VLW'(VL_MAX)) ? VLW'(VL_MAX) : vl;
  assign accept = start & ~busy;
  assign last   = busy & (VLW'(idx) == vl_q - VLW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      vl_q <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (vl_eff == '0) begin
          done <= 1'b1;
        end else begin
          busy <= 1'b1;
          idx  <= '0;
          vl_q <= vl_eff;
        end
      end else if (busy) begin
        if (last) begin
          busy <= 1'b0;
          idx  <= '0;
          done <= 1'b1;
        end else begin
          idx <= idx + IDXW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/vseq_alu.sv
module vseq_alu
  import vseq_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [2:0]      op,
  input  logic [1:0]      ew,
  output logic [XLEN-1:0] y
);
  assign y = elem_op(a, b, op, ew);
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
  import vseq_pkg::*;
#(
  parameter int VL_MAX = 64,
  parameter int RF_AW  = 7,
  localparam int IDXW = $clog2(VL_MAX),
  localparam int VLW  = $clog2(VL_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VLW-1:0]   vl,
  input  logic             pred_en,
  input  logic [VL_MAX-1:0] pred_mask,
  input  logic [1:0]       ew_code,
  input  logic [2:0]       op_sel,
  input  logic [RF_AW-1:0] base_d,
  input  logic [RF_AW-1:0] base_a,
  input  logic [RF_AW-1:0] base_b,
  output logic [RF_AW-1:0] rd_addr_a,
  output logic [RF_AW-1:0] rd_addr_b,
  input  logic [XLEN-1:0]  rd_data_a,
  input  logic [XLEN-1:0]  rd_data_b,
  output logic             busy,
  output logic [IDXW-1:0]  elem_idx,
  output logic             wr_en,
  output logic [RF_AW-1:0] wr_addr,
  output logic [XLEN-1:0]  wr_data,
  output logic             done
);
  localparam int NPORT = 3;

  logic              accept;
  logic              last;
  logic              pen_q;
  logic [VL_MAX-1:0] mask_q;
  logic [1:0]        ew_q;
  logic [2:0]        op_q;
  logic [RF_AW-1:0]  base_in [NPORT];
  logic [RF_AW-1:0]  base_q  [NPORT];
  logic [RF_AW-1:0]  addr    [NPORT];
  logic              elem_live;

  vseq_subctr #(.VL_MAX(VL_MAX)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .vl     (vl),
    .accept (accept),
    .busy   (busy),
    .idx    (elem_idx),
    .last   (last),
    .done   (done)
  );

  assign base_in[0] = base_d;
  assign base_in[1] = base_a;
  assign base_in[2] = base_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pen_q  <= 1'b0;
      mask_q <= '0;
      ew_q   <= '0;
      op_q   <= '0;
    end else if (accept) begin
      pen_q  <= pred_en;
      mask_q <= pred_mask;
      ew_q   <= ew_code;
      op_q   <= op_sel;
    end
  end

  for (genvar k = 0; k < NPORT; k++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n) base_q[k] <= '0;
      else if (accept) base_q[k] <= base_in[k];
    end
    assign addr[k] = base_q[k] + RF_AW'(elem_idx);
  end

  assign wr_addr   = addr[0];
  assign rd_addr_a = addr[1];
  assign rd_addr_b = addr[2];

  assign elem_live = ~pen_q | mask_q[elem_idx];
  assign wr_en     = busy & elem_live;

  vseq_alu u_alu (
    .a  (rd_data_a),
    .b  (rd_data_b),
    .op (op_q),
    .ew (ew_q),
    .y  (wr_data)
  );
endmodule

// File: rtl/vec_elem_seq_chk.sv
module vec_elem_seq_chk #(
  parameter int VL_MAX = 64,
  localparam int IDXW = $clog2(VL_MAX),
  localparam int VLW  = $clog2(VL_MAX + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [VLW-1:0]  vl,
  input logic            busy,
  input logic [IDXW-1:0] elem_idx,
  input logic            wr_en,
  input logic [1:0]      ew_q,
  input logic [63:0]     wr_data,
  input logic            done
);
  p_first_idx_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> elem_idx == '0);

  p_idx_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> elem_idx == $past(elem_idx) + IDXW'(1));

  p_end_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(start && vl == '0)) |=> !done);

  p_zero_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && vl == '0) |=> (done && !busy));

  p_write_in_loop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  p_width8_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ew_q == 2'b11) |-> wr_data[63:8] == '0);

  p_width16_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ew_q == 2'b10) |-> wr_data[63:16] == '0);

  p_width32_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ew_q == 2'b01) |-> wr_data[63:32] == '0);

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && !wr_en));
endmodule

bind vec_elem_seq vec_elem_seq_chk #(.VL_MAX(VL_MAX)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .vl       (vl),
  .busy     (busy),
  .elem_idx (elem_idx),
  .wr_en    (wr_en),
  .ew_q     (ew_q),
  .wr_data  (wr_data),
  .done     (done)
);

// File: tb/vec_elem_seq_tb_top.sv
module vec_elem_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  vl = '0;
  logic        pred_en = 1'b0;
  logic [63:0] pred_mask = '0;
  logic [1:0]  ew_code = '0;
  logic [2:0]  op_sel = '0;
  logic [6:0]  base_d = '0, base_a = '0, base_b = '0;
  logic [6:0]  rd_addr_a, rd_addr_b, wr_addr;
  logic [63:0] rd_data_a, rd_data_b, wr_data;
  logic        busy, wr_en, done;
  logic [5:0]  elem_idx;

  logic [63:0] rf  [128];
  logic [63:0] exp_rf [128];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  assign rd_data_a = rf[rd_addr_a];
  assign rd_data_b = rf[rd_addr_b];
  always @(posedge clk) if (wr_en) rf[wr_addr] <= wr_data;

  vec_elem_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .pred_en(pred_en),
    .pred_mask(pred_mask), .ew_code(ew_code), .op_sel(op_sel),
    .base_d(base_d), .base_a(base_a), .base_b(base_b),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
    .busy(busy), .elem_idx(elem_idx), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done)
  );

  // fields: vl[97:91] pen[90] mask[89:26] ew[25:24] op[23:21] bd[20:14] ba[13:7] bb[6:0]
  localparam logic [97:0] TBL [8] = '{
    {7'd8,  1'b0, 64'h0,                  2'd0, 3'd0, 7'd64,  7'd0,   7'd16},
    {7'd16, 1'b1, 64'hAAAA,               2'd1, 3'd1, 7'd80,  7'd8,   7'd40},
    {7'd12, 1'b1, 64'h0F3,                2'd3, 3'd0, 7'd96,  7'd2,   7'd50},
    {7'd10, 1'b0, 64'h0,                  2'd2, 3'd1, 7'd20,  7'd30,  7'd31},
    {7'd9,  1'b1, 64'h1FF,                2'd0, 3'd2, 7'd60,  7'd61,  7'd62},
    {7'd7,  1'b0, 64'h0,                  2'd1, 3'd3, 7'd10,  7'd70,  7'd90},
    {7'd20, 1'b1, 64'hFFFFF,              2'd2, 3'd4, 7'd120, 7'd100, 7'd110},
    {7'd64, 1'b1, 64'h5555555555555555,   2'd3, 3'd6, 7'd0,   7'd64,  7'd0}
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [63:0] ref_result(input logic [63:0] a, input logic [63:0] b,
                                             input logic [2:0] op, input logic [1:0] ew);
    logic [63:0] r;
    int sh;
    if (op == 3'd0) r = a + b;
    else if (op == 3'd1) r = a + ~b + 64'd1;
    else if (op == 3'd2) r = a & b;
    else if (op == 3'd3) r = a | b;
    else if (op == 3'd4) r = a ^ b;
    else r = 64'd0;
    sh = (ew == 2'd0) ? 0 : (ew == 2'd1) ? 32 : (ew == 2'd2) ? 48 : 56;
    return (r << sh) >> sh;
  endfunction

  task automatic run(input logic [6:0] n, input logic pen, input logic [63:0] msk,
                     input logic [1:0] ew, input logic [2:0] op,
                     input logic [6:0] bd, input logic [6:0] ba, input logic [6:0] bb,
                     input bit poke, input string tag);
    int eff, exp_iss, cyc, iss, bad_k;
    bit fin;
    logic [63:0] bad_a, bad_e;
    for (int k = 0; k < 128; k++) begin
      rf[k] = {32'(k) * 32'h9E3779B9, ~(32'(k) * 32'h85EBCA6B)};
      exp_rf[k] = rf[k];
    end
    eff = (n > 7'd64) ? 64 : int'(n);
    exp_iss = 0;
    for (int i = 0; i < eff; i++) begin
      if (!pen || msk[i]) begin
        exp_rf[7'(bd + 7'(i))] = ref_result(exp_rf[7'(ba + 7'(i))], exp_rf[7'(bb + 7'(i))], op, ew);
        exp_iss++;
      end
    end
    @(negedge clk);
    vl = n; pred_en = pen; pred_mask = msk; ew_code = ew; op_sel = op;
    base_d = bd; base_a = ba; base_b = bb; start = 1'b1;
    cyc = 0; iss = 0; fin = 0;
    while (!fin && cyc < 300) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && cyc == 3) begin
        // R8: a second start mid-loop with different settings must be ignored
        start = 1'b1; vl = 7'd2; op_sel = 3'd2; ew_code = 2'd0; pred_en = 1'b0;
        base_d = 7'd5;
      end
      cyc++;
      if (wr_en) iss++;
      if (done) fin = 1;
    end
    start = 1'b0;
    check(fin, {tag, " R1 watchdog: done never seen"}, cyc, eff + 1);
    check(cyc == eff + 1, {tag, " R1/R2/R9 cycles start to done"}, cyc, eff + 1);
    check(iss == exp_iss, {tag, " R3/R4 element write count"}, iss, exp_iss);
    @(negedge clk);
    check(!done && !busy, {tag, " R1 done is a single pulse"}, {done, busy}, 0);
    bad_k = -1; bad_a = '0; bad_e = '0;
    for (int k = 0; k < 128; k++)
      if (bad_k < 0 && rf[k] !== exp_rf[k]) begin
        bad_k = k; bad_a = rf[k]; bad_e = exp_rf[k];
      end
    check(bad_k < 0, $sformatf("%s R5 R6 R7 R8 register %0d contents", tag, bad_k), bad_a, bad_e);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 128; k++) rf[k] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !wr_en, "R10 outputs quiet in reset", {busy, done, wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !wr_en, "R10 outputs quiet after reset", {busy, done, wr_en}, 0);

    for (int v = 0; v < 8; v++) begin
      run(TBL[v][97:91], TBL[v][90], TBL[v][89:26], TBL[v][25:24], TBL[v][23:21],
          TBL[v][20:14], TBL[v][13:7], TBL[v][6:0], 1'b0, $sformatf("vec%0d", v));
    end

    run(7'd0,   1'b0, 64'h0, 2'd0, 3'd0, 7'd0,  7'd1,  7'd2,  1'b0, "R2 zero length");
    run(7'd100, 1'b0, 64'h0, 2'd1, 3'd0, 7'd64, 7'd0,  7'd32, 1'b0, "R9 clamp");
    run(7'd10,  1'b0, 64'h0, 2'd3, 3'd0, 7'd40, 7'd10, 7'd20, 1'b1, "R8 busy start");
    run(7'd6,   1'b1, 64'h0, 2'd0, 3'd4, 7'd30, 7'd31, 7'd32, 1'b0, "R3 all masked");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule